// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block is the receive side of a clocked serial port that acts as the clock master. It drives a shift clock out on `sck` and samples the data line `sd_in` on each falling edge of that clock. Each word is 8 bits, or 9 bits when 9-bit mode is selected. Bits arrive least significant first. A programmable divider sets the shift clock period. When no word is in progress, the clock stays low.

Reception can be started in two ways. `single_req` is a one-cycle pulse that requests exactly one word; the pending request clears itself in hardware once that word is taken in. `cont_en` is a level enable that receives words back to back for as long as it stays high. When both are active, continuous reception governs. Each finished word goes into a one-entry buffer that has a ready flag and an optional interrupt. If a word finishes while the buffer is still full, the new word is dropped and an overrun is flagged. The overrun blocks all further reception until `cont_en` goes from high to low.

Top module: `sync_master_rx`

## Requirements
- R1: After reset, `sck`, `rx_ready`, `ovr_err`, `single_pend` and `rx_irq` are all 0.
- R2: While a word is in progress, `sck` stays high for `baud_div`+1 clock cycles, then low for `baud_div`+1 clock cycles, for every bit. `sck` is 0 whenever no word is in progress.
- R3: Received bit i (bit 0 first) is the level of `sd_in` sampled on the i-th falling edge of `sck` within the word. Bit i is placed at position i of the word.
- R4: A one-cycle pulse on `single_req`, with `cont_en` low, sets `single_pend`. The block then receives exactly one word, giving exactly 8 or 9 rising edges of `sck`. `single_pend` returns to 0 when the last bit is sampled, and `sck` then stays low.
- R5: While `cont_en` is 1, words are received one after another. Dropping `cont_en` in the middle of a word abandons that word: `sck` goes low and stays low, and `rx_ready` is not set.
- R6: When `single_req` and `cont_en` are active together, reception continues past the first word. `single_pend` clears after that first word.
- R7: With `mode9` = 1, a word has 9 bits. Bits 7..0 appear on `rx_data` and bit 8 appears on `rx_bit9`. With `mode9` = 0, `rx_bit9` reads 0.
- R8: `rx_ready` rises one clock after the last bit of a word is sampled. A one-cycle pulse on `rd_strobe` clears it. `rx_irq` equals `rx_ready` AND `irq_en`.
- R9: If a word finishes while `rx_ready` is 1 and no read happens in that cycle, `ovr_err` is set. `rx_data` and `rx_bit9` keep the older word, and no new word starts while `ovr_err` is 1.
- R10: `ovr_err` is cleared on the clock edge after `cont_en` falls from 1 to 0. Reception can then start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Shift clock half-period minus one, in clock cycles |
| mode9 | input | 1 | 1 selects 9-bit words |
| single_req | input | 1 | Pulse that requests one word |
| cont_en | input | 1 | Level enable for continuous reception; its falling edge clears overrun |
| irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Pulse that marks the buffered word as read |
| sd_in | input | 1 | Serial data line |
| sck | output | 1 | Shift clock driven by this block; idles low |
| rx_data | output | 8 | Low 8 bits of the buffered word |
| rx_bit9 | output | 1 | Ninth bit of the buffered word |
| rx_ready | output | 1 | Buffered word not yet read |
| ovr_err | output | 1 | Overrun error |
| single_pend | output | 1 | Single-word request still outstanding |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench acts as a slave that changes `sd_in` just after each rising edge of `sck`. This exposes a design that samples on the wrong edge or shifts bits in the wrong order, because such a design would return a scrambled byte. The bench counts `sck` rising edges after a single request. A design that does not clear its pending request would keep clocking and exceed 8 or 9 edges. An overrun test leaves the buffer unread while a second word arrives. A design that overwrites the buffer, or that keeps receiving while the error is set, would show the new byte or extra clock edges. Further tests drop `cont_en` in the middle of a word, run with both enables set, and use a divider of zero. These catch designs that finish the abandoned word, stop after one word in combined mode, or get the half-period wrong.

// File: rtl/smr_pkg.sv
package smr_pkg;
    localparam int DATA_W = 8;
    localparam int WORD_W = DATA_W + 1;
    localparam int IDX_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              b9;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    typedef enum logic {ST_IDLE, ST_SHIFT} shift_st_t;

    function automatic logic [IDX_W-1:0] last_idx(input logic nine);
        return nine ? IDX_W'(WORD_W - 1) : IDX_W'(DATA_W - 1);
    endfunction
endpackage

// File: rtl/smr_baud.sv
module smr_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || cnt_q == '0) cnt_q <= div;
        else                            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/smr_ctrl.sv
module smr_ctrl
    import smr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cont_en,
    input  logic              single_req,
    input  logic              ovr,
    input  logic              mode9,
    input  logic              sd_in,
    output logic              running,
    output logic              sck,
    output logic              single_pend,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    shift_st_t        st_q;
    logic [IDX_W-1:0] bit_q;
    logic             go;

    assign go      = (cont_en || single_pend) && !ovr;
    assign running = (st_q == ST_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            sck         <= 1'b0;
            bit_q       <= '0;
            word        <= '0;
            single_pend <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    sck <= 1'b0;
                    if (go) begin
                        st_q  <= ST_SHIFT;
                        bit_q <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (!go) begin
                        st_q <= ST_IDLE;
                        sck  <= 1'b0;
                    end else if (tick) begin
                        if (!sck) begin
                            sck <= 1'b1;
                        end else begin
                            sck         <= 1'b0;
                            word[bit_q] <= sd_in;
                            if (bit_q == last_idx(mode9)) begin
                                st_q        <= ST_IDLE;
                                done        <= 1'b1;
                                single_pend <= 1'b0;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
            if (single_req) single_pend <= 1'b1;
        end
    end

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !sck);

    // R9
    ovr_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && st_q == ST_IDLE) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/smr_rxbuf.sv
module smr_rxbuf
    import smr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [WORD_W-1:0] word,
    input  logic              mode9,
    input  logic              rd,
    input  logic              cont_en,
    input  logic              irq_en,
    output rx_word_t          buf_q,
    output logic              ready,
    output logic              ovr,
    output logic              irq
);
    logic cont_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            ready  <= 1'b0;
            ovr    <= 1'b0;
            cont_q <= 1'b0;
        end else begin
            cont_q <= cont_en;
            if (cont_q && !cont_en) ovr <= 1'b0;
            if (done) begin
                if (ready && !rd) begin
                    ovr <= 1'b1;
                end else begin
                    buf_q.data <= word[DATA_W-1:0];
                    buf_q.b9   <= mode9 && word[DATA_W];
                    ready      <= 1'b1;
                end
            end else if (rd) begin
                ready <= 1'b0;
            end
        end
    end

    assign irq = ready && irq_en;

    // R9
    ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(ready));

    // R9
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ready && !rd) |=> ($stable(buf_q) && ovr));

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !done) |=> !ready);
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
    import smr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             mode9,
    input  logic             single_req,
    input  logic             cont_en,
    input  logic             irq_en,
    input  logic             rd_strobe,
    input  logic             sd_in,
    output logic             sck,
    output logic [7:0]       rx_data,
    output logic             rx_bit9,
    output logic             rx_ready,
    output logic             ovr_err,
    output logic             single_pend,
    output logic             rx_irq
);
    logic              tick, running, done;
    logic [WORD_W-1:0] word;
    rx_word_t          buf_w;

    smr_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(running), .div(baud_div), .tick(tick)
    );

    smr_ctrl u_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .cont_en(cont_en),
        .single_req(single_req), .ovr(ovr_err), .mode9(mode9), .sd_in(sd_in),
        .running(running), .sck(sck), .single_pend(single_pend),
        .done(done), .word(word)
    );

    smr_rxbuf u_buf (
        .clk(clk), .rst(rst), .done(done), .word(word), .mode9(mode9),
        .rd(rd_strobe), .cont_en(cont_en), .irq_en(irq_en),
        .buf_q(buf_w), .ready(rx_ready), .ovr(ovr_err), .irq(rx_irq)
    );

    assign rx_data = buf_w.data;
    assign rx_bit9 = buf_w.b9;

    // R1
    reset_flags_chk: assert property (@(posedge clk)
        rst |=> (!rx_ready && !ovr_err && !sck && !single_pend));
endmodule

// File: tb/sim_sync_master_rx.sv
module sim_sync_master_rx;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] baud_div = 8'd2;
    logic mode9 = 1'b0, single_req = 1'b0, cont_en = 1'b0;
    logic irq_en = 1'b0, rd_strobe = 1'b0, sd_in = 1'b0;
    logic sck, rx_bit9, rx_ready, ovr_err, single_pend, rx_irq;
    logic [7:0] rx_data;

    int total = 0, bad = 0, cycles = 0;

    // slave model state
    logic [8:0] words [4];
    int slv_gen = 0, seen_gen = 0, widx = 0, bidx = 0;
    int rises = 0, hcnt = 0, last_high = 0;
    logic sck_p = 1'b0;

    sync_master_rx u0 (
        .clk(clk), .rst(rst), .baud_div(baud_div), .mode9(mode9),
        .single_req(single_req), .cont_en(cont_en), .irq_en(irq_en),
        .rd_strobe(rd_strobe), .sd_in(sd_in), .sck(sck), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_ready(rx_ready), .ovr_err(ovr_err),
        .single_pend(single_pend), .rx_irq(rx_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) begin
        if (seen_gen != slv_gen) begin
            seen_gen = slv_gen; widx = 0; bidx = 0; rises = 0;
        end
        if (sck && !sck_p) begin
            sd_in = words[widx][bidx];
            rises++;
            if (bidx == (mode9 ? 8 : 7)) begin bidx = 0; widx = (widx + 1) % 4; end
            else bidx++;
        end
        if (sck) hcnt++;
        else if (sck_p) begin last_high = hcnt; hcnt = 0; end
        sck_p = sck;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic new_gen(input logic [8:0] a, b, c, d);
        words[0] = a; words[1] = b; words[2] = c; words[3] = d;
        slv_gen++;
        step();
    endtask

    task automatic pulse_single();
        single_req = 1'b1; step(); single_req = 1'b0;
    endtask

    task automatic do_read();
        rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!rx_ready && n < 5000) begin step(); n++; end
        chk({req, " ready timeout"}, int'(rx_ready), 1);
    endtask

    task automatic t_reset();
        chk("R1 sck", int'(sck), 0);
        chk("R1 ready", int'(rx_ready), 0);
        chk("R1 ovr", int'(ovr_err), 0);
        chk("R1 pend", int'(single_pend), 0);
        chk("R1 irq", int'(rx_irq), 0);
    endtask

    task automatic t_single8();
        baud_div = 8'd2; mode9 = 1'b0;
        new_gen(9'h0A5, 9'h0FF, 9'h0FF, 9'h0FF);
        pulse_single();
        chk("R4 pend set", int'(single_pend), 1);
        wait_ready("R4");
        chk("R3 data lsb first", int'(rx_data), 'hA5);
        chk("R7 bit9 zero", int'(rx_bit9), 0);
        chk("R2 high width", last_high, 3);
        chk("R4 rises", rises, 8);
        chk("R4 pend cleared", int'(single_pend), 0);
        step(40);
        chk("R4 no more clocks", rises, 8);
        chk("R2 idle low", int'(sck), 0);
        chk("R8 irq masked", int'(rx_irq), 0);
        irq_en = 1'b1; step();
        chk("R8 irq on", int'(rx_irq), 1);
        do_read();
        chk("R8 read clears ready", int'(rx_ready), 0);
        chk("R8 irq off", int'(rx_irq), 0);
        irq_en = 1'b0;
    endtask

    task automatic t_nine();
        baud_div = 8'd0; mode9 = 1'b1;
        new_gen(9'h13C, 9'h000, 9'h000, 9'h000);
        pulse_single();
        wait_ready("R7");
        chk("R7 data", int'(rx_data), 'h3C);
        chk("R7 bit9", int'(rx_bit9), 1);
        chk("R2 high width div0", last_high, 1);
        chk("R7 nine clocks", rises, 9);
        do_read();
        mode9 = 1'b0;
    endtask

    task automatic t_cont();
        int r;
        baud_div = 8'd1;
        new_gen(9'h05A, 9'h0C3, 9'h00F, 9'h0E7);
        cont_en = 1'b1;
        wait_ready("R5 w0"); chk("R5 word0", int'(rx_data), 'h5A); do_read();
        wait_ready("R5 w1"); chk("R5 word1", int'(rx_data), 'hC3); do_read();
        wait_ready("R5 w2"); chk("R5 word2", int'(rx_data), 'h0F); do_read();
        step(10);
        cont_en = 1'b0; step(2);
        r = rises;
        step(40);
        chk("R5 stop clocks", rises, r);
        chk("R5 sck low", int'(sck), 0);
        chk("R5 partial dropped", int'(rx_ready), 0);
    endtask

    task automatic t_both();
        baud_div = 8'd1;
        new_gen(9'h066, 9'h099, 9'h000, 9'h000);
        cont_en = 1'b1; single_req = 1'b1; step(); single_req = 1'b0;
        wait_ready("R6 w0");
        chk("R6 word0", int'(rx_data), 'h66);
        chk("R6 pend cleared", int'(single_pend), 0);
        do_read();
        wait_ready("R6 w1");
        chk("R6 word1", int'(rx_data), 'h99);
        do_read();
        cont_en = 1'b0; step(40);
        chk("R6 stopped", int'(rx_ready), 0);
    endtask

    task automatic t_over();
        int r, n;
        baud_div = 8'd0;
        new_gen(9'h011, 9'h022, 9'h033, 9'h044);
        pulse_single();
        wait_ready("R9 first");
        chk("R9 first data", int'(rx_data), 'h11);
        pulse_single();
        n = 0;
        while (!ovr_err && n < 2000) begin step(); n++; end
        chk("R9 ovr set", int'(ovr_err), 1);
        chk("R9 old data kept", int'(rx_data), 'h11);
        chk("R9 ready held", int'(rx_ready), 1);
        r = rises;
        step(30);
        chk("R9 halted", rises, r);
        cont_en = 1'b1; step(3);
        chk("R9 blocked under cont", rises, r);
        chk("R10 ovr until fall", int'(ovr_err), 1);
        cont_en = 1'b0; step();
        chk("R10 ovr cleared", int'(ovr_err), 0);
        chk("R10 buffer intact", int'(rx_data), 'h11);
        do_read();
        pulse_single();
        wait_ready("R10 resume");
        chk("R10 resume data", int'(rx_data), 'h33);
        do_read();
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step();
        t_reset();
        t_single8();
        t_nine();
        t_cont();
        t_both();
        t_over();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule